// File: doc/BRIEF.md
# Periodic Reload Interrupt Timer

This block is a single down-counting timer that raises an interrupt again and again at a programmed period. Software programs it through a 32-bit register port. The port exposes a control word and a separate write-only acknowledge location. The control word holds four things:

- a 28-bit period
- a run bit
- an interrupt-enable bit
- a sticky event flag

The counter moves only on clock cycles where `tick_en` is high. That strobe stands for the reference rate, for example one pulse per 38.4 MHz reference edge.

On every expiry the timer sets its event flag and starts the next period of the same length at once. The interrupt request is the event flag gated by the interrupt-enable bit. An interrupt router outside this block steers that request to a core.

Software writes the acknowledge location for two purposes:

- to clear the flag;
- to restart the current period from the full programmed length, without rewriting the period.

Top module: `periodic_irq_timer`

## Requirements
- R1: The control word at byte offset 0x34 reads back as bits [27:0] period, bit 28 run, bit 29 interrupt enable, bit 30 spare (stored and read back), bit 31 event flag. A write there replaces the whole word, event flag included.
- R2: After reset the control word reads 0, `irq` is low and the counter does not advance.
- R3: A control write with bit 28 set loads the period P. The counter steps only on cycles with `tick_en` high. The event flag becomes set on the P-th such tick after the write, and not before.
- R4: At expiry the next period of the same length begins immediately, so the flag sets again after another P ticks.
- R5: A control write with bit 28 clear stops counting: no number of ticks sets the event flag.
- R6: Writing the acknowledge location (byte offset 0x38) with bit 31 set clears the event flag and leaves every other control bit unchanged. A read of offset 0x38 always returns 0.
- R7: An acknowledge write with bit 30 set restarts the period from the full length P while bit 28 is set. While bit 28 is clear it has no effect.
- R8: `irq` is high exactly when control bits 29 and 31 are both set.
- R9: A period of 0 never expires and never sets the event flag.
- R10: When an expiry and a flag-clearing acknowledge (bit 31 only) fall on the same cycle, the event flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Reference tick strobe; the counter steps on cycles where it is high |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request: event flag AND interrupt enable |

## Verification
The hardest state to reach from the ports is a flag-clearing acknowledge that lands on the very tick at which the counter expires. The stimulus programs a short period and counts `tick_en` pulses until exactly one tick remains. It then issues the acknowledge write in the same cycle as the final tick and checks that the flag survives. A second hard corner is a restart acknowledge issued in the middle of a period. To expose it, the bench counts ticks past the point where the old period would have ended and confirms that no expiry occurs until the full length has run again.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;

    localparam int WORD_W      = 32;
    localparam int RLD_W       = 28;
    localparam int ACK_CLR_BIT = 31;
    localparam int ACK_RLD_BIT = 30;

    typedef logic [RLD_W-1:0] cnt_t;

    // Software-visible layout: flag at the top, period in the low bits.
    typedef struct packed {
        logic flag;
        logic spare;
        logic irq_en;
        logic run;
        cnt_t period;
    } ctrl_t;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_STEP = 2'd2
    } cnt_cmd_e;

    // A control write decides first, then a restart, then a tick.
    function automatic cnt_cmd_e pick_cmd(
        input logic wr_ctrl,
        input logic new_run,
        input logic ack_rld,
        input logic cur_run,
        input logic tick
    );
        cnt_cmd_e c;
        if (wr_ctrl)
            c = new_run ? CNT_LOAD : CNT_HOLD;
        else if (ack_rld && cur_run)
            c = CNT_LOAD;
        else if (cur_run && tick)
            c = CNT_STEP;
        else
            c = CNT_HOLD;
        return c;
    endfunction

    function automatic logic at_terminal(input cnt_t c);
        return c == cnt_t'(1);
    endfunction

endpackage

// File: rtl/pit_decode.sv
`timescale 1ns/1ps
module pit_decode
    import pit_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h34,
    parameter logic [ADDR_W-1:0] ACK_OFS  = 'h38
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  ctrl_t             ctrl_q,
    output logic              wr_ctrl,
    output logic              ack_clr,
    output logic              ack_rld,
    output logic [WORD_W-1:0] rdata
);

    logic hit_ctrl;
    logic hit_ack;

    always_comb begin
        hit_ctrl = (addr == CTRL_OFS);
        hit_ack  = (addr == ACK_OFS);
        wr_ctrl  = wr_en && hit_ctrl;
        ack_clr  = wr_en && hit_ack && wdata[ACK_CLR_BIT];
        ack_rld  = wr_en && hit_ack && wdata[ACK_RLD_BIT];
    end

    // The acknowledge location and unmapped offsets read as zero.
    always_comb begin
        if (hit_ctrl)
            rdata = ctrl_q;
        else
            rdata = '0;
    end

endmodule

// File: rtl/pit_ctrl_reg.sv
`timescale 1ns/1ps
module pit_ctrl_reg
    import pit_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_ctrl,
    input  ctrl_t wr_word,
    input  logic  ack_clr,
    input  logic  expire,
    output ctrl_t ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= wr_word;
        end else begin
            // Set follows clear, so a simultaneous expiry is kept.
            if (ack_clr)
                ctrl_q.flag <= 1'b0;
            if (expire)
                ctrl_q.flag <= 1'b1;
        end
    end

endmodule

// File: rtl/pit_counter.sv
`timescale 1ns/1ps
module pit_counter
    import pit_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cnt_cmd_e cmd,
    input  cnt_t     load_val,
    input  cnt_t     period,
    output cnt_t     count_q,
    output logic     expire
);

    cnt_t count_d;

    always_comb begin
        expire  = (cmd == CNT_STEP) && at_terminal(count_q);
        count_d = count_q;
        unique case (cmd)
            CNT_LOAD: count_d = load_val;
            CNT_STEP: begin
                if (at_terminal(count_q))
                    count_d = period;
                else if (count_q != '0)
                    count_d = count_q - cnt_t'(1);
            end
            default:  count_d = count_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else
            count_q <= count_d;
    end

endmodule

// File: rtl/periodic_irq_timer.sv
`timescale 1ns/1ps
module periodic_irq_timer
    import pit_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h34,
    parameter logic [ADDR_W-1:0] ACK_OFS  = 'h38
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              irq
);

    ctrl_t    ctrl_q;
    ctrl_t    wr_word;
    cnt_t     count_q;
    cnt_t     load_val;
    cnt_cmd_e cmd;
    logic     wr_ctrl;
    logic     ack_clr;
    logic     ack_rld;
    logic     expire;

    assign wr_word = ctrl_t'(wdata);

    pit_decode #(
        .ADDR_W   (ADDR_W),
        .CTRL_OFS (CTRL_OFS),
        .ACK_OFS  (ACK_OFS)
    ) u_dec (
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .ctrl_q  (ctrl_q),
        .wr_ctrl (wr_ctrl),
        .ack_clr (ack_clr),
        .ack_rld (ack_rld),
        .rdata   (rdata)
    );

    always_comb begin
        cmd      = pick_cmd(wr_ctrl, wr_word.run, ack_rld, ctrl_q.run, tick_en);
        load_val = wr_ctrl ? wr_word.period : ctrl_q.period;
    end

    pit_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .load_val (load_val),
        .period   (ctrl_q.period),
        .count_q  (count_q),
        .expire   (expire)
    );

    pit_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_ctrl),
        .wr_word (wr_word),
        .ack_clr (ack_clr),
        .expire  (expire),
        .ctrl_q  (ctrl_q)
    );

    assign irq = ctrl_q.flag && ctrl_q.irq_en;

endmodule

// File: rtl/pit_checker.sv
`timescale 1ns/1ps
module pit_checker #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h34,
    parameter logic [ADDR_W-1:0] ACK_OFS  = 'h38
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              irq,
    input logic [31:0]       ctrl,
    input logic [27:0]       count,
    input logic              expire
);

    // R2: first cycle out of reset shows a cleared word and no request
    assert_rst_clear_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl == 32'h0 && !irq));

    // R3: an expiry is visible as a set flag on the next cycle
    assert_expire_sets_flag_R3: assert property (@(posedge clk) disable iff (rst)
        expire |=> ctrl[31]);

    // R5: with the run bit clear and no write, the counter is frozen
    assert_stopped_R5: assert property (@(posedge clk) disable iff (rst)
        (!ctrl[28] && !wr_en) |=> $stable(count));

    // R6: a clearing acknowledge without a coincident expiry drops the flag
    assert_ack_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ACK_OFS && wdata[31] && !expire) |=> !ctrl[31]);

    // R6: the acknowledge location reads zero
    assert_ack_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (addr == ACK_OFS) |-> (rdata == 32'h0));

    // R9: a zero period never expires
    assert_zero_period_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl[27:0] == 28'h0) |-> !expire);

    // R10: expiry wins over a simultaneous clearing acknowledge
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (expire && wr_en && addr == ACK_OFS && wdata[31]) |=> ctrl[31]);

    // R1: the control offset reads back the stored word
    assert_readback_R1: assert property (@(posedge clk) disable iff (rst)
        (addr == CTRL_OFS) |-> (rdata == ctrl));

endmodule

bind periodic_irq_timer pit_checker #(
    .ADDR_W   (ADDR_W),
    .CTRL_OFS (CTRL_OFS),
    .ACK_OFS  (ACK_OFS)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .irq    (irq),
    .ctrl   (ctrl_q),
    .count  (count_q),
    .expire (expire)
);

// File: tb/sim_periodic_irq_timer.sv
`timescale 1ns/1ps
module sim_periodic_irq_timer;

    localparam logic [7:0] CTRL_A = 8'h34;
    localparam logic [7:0] ACK_A  = 8'h38;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = CTRL_A;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    periodic_irq_timer u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // op[74:73] 0 none/1 control write/2 ack write, data[72:41],
    // ticks[40:33], expected control word[32:1], expected irq[0]
    localparam int NV = 15;
    localparam logic [74:0] VEC [NV] = '{
        {2'd1, 32'h30000005, 8'd4,  32'h30000005, 1'b0}, // R3 not yet
        {2'd0, 32'h00000000, 8'd1,  32'hB0000005, 1'b1}, // R3 P-th tick
        {2'd2, 32'h80000000, 8'd0,  32'h30000005, 1'b0}, // R6 clear
        {2'd0, 32'h00000000, 8'd4,  32'h30000005, 1'b0}, // R4
        {2'd0, 32'h00000000, 8'd1,  32'hB0000005, 1'b1}, // R4 again
        {2'd2, 32'h80000000, 8'd3,  32'h30000005, 1'b0}, // R6
        {2'd2, 32'h40000000, 8'd4,  32'h30000005, 1'b0}, // R7 restart
        {2'd0, 32'h00000000, 8'd1,  32'hB0000005, 1'b1}, // R7 full length
        {2'd1, 32'h20000005, 8'd10, 32'h20000005, 1'b0}, // R5 stopped
        {2'd1, 32'h80000005, 8'd0,  32'h80000005, 1'b0}, // R1 flag by write
        {2'd1, 32'hA0000005, 8'd0,  32'hA0000005, 1'b1}, // R8
        {2'd2, 32'h40000000, 8'd5,  32'hA0000005, 1'b1}, // R7 ignored
        {2'd1, 32'h30000000, 8'd40, 32'h30000000, 1'b0}, // R9
        {2'd1, 32'h30000001, 8'd1,  32'hB0000001, 1'b1}, // R3 period 1
        {2'd1, 32'h50000003, 8'd3,  32'hD0000003, 1'b0}  // R8 gated, R1 spare
    };

    task automatic check(input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d,
                             input logic with_tick);
        wr_en = 1'b1; addr = a; wdata = d; tick_en = with_tick;
        @(negedge clk);
        wr_en = 1'b0; addr = CTRL_A; wdata = '0; tick_en = 1'b0;
    endtask

    task automatic run_ticks(input int n, input bit sparse);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
            if (sparse) @(negedge clk);
        end
    endtask

    task automatic read_ctrl(output logic [31:0] v);
        addr = CTRL_A;
        #1 v = rdata;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2 reset state
        read_ctrl(v);
        check("R2 ctrl after reset", v, 32'h0);
        check("R2 irq after reset", {31'h0, irq}, 32'h0);

        for (int k = 0; k < NV; k++) begin
            logic [74:0] e;
            e = VEC[k];
            if (e[74:73] == 2'd1) bus_write(CTRL_A, e[72:41], 1'b0);
            else if (e[74:73] == 2'd2) bus_write(ACK_A, e[72:41], 1'b0);
            run_ticks(int'(e[40:33]), 1'b0);
            read_ctrl(v);
            check($sformatf("R1/R3-R9 vector %0d ctrl", k), v, e[32:1]);
            check($sformatf("R8 vector %0d irq", k), {31'h0, irq}, {31'h0, e[0]});
        end

        // R6 acknowledge reads zero while the flag is set
        addr = ACK_A;
        #1 check("R6 ack read", rdata, 32'h0);
        addr = CTRL_A;

        // R3 sparse ticks: only tick_en cycles count
        bus_write(CTRL_A, 32'h30000003, 1'b0);
        run_ticks(2, 1'b1);
        read_ctrl(v);
        check("R3 sparse before", v, 32'h30000003);
        run_ticks(1, 1'b1);
        read_ctrl(v);
        check("R3 sparse after", v, 32'hB0000003);

        // R10 clear ack on the expiring tick
        bus_write(CTRL_A, 32'h30000003, 1'b0);
        run_ticks(2, 1'b0);
        bus_write(ACK_A, 32'h80000000, 1'b1);
        read_ctrl(v);
        check("R10 set wins", v, 32'hB0000003);
        check("R10 irq", {31'h0, irq}, 32'h1);

        // R2 reset mid-run, then counting stays stopped
        bus_write(CTRL_A, 32'hB0000002, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        read_ctrl(v);
        check("R2 ctrl after mid reset", v, 32'h0);
        check("R2 irq after mid reset", {31'h0, irq}, 32'h0);
        run_ticks(8, 1'b0);
        read_ctrl(v);
        check("R2 no counting after reset", v, 32'h0);

        finish_run();
    end

endmodule